// File: doc/BRIEF.md
# Multiplexed Sensor Serial Target Emulator

This block models the device end of a four-wire serial sensor port so that a host controller can be tested against it in simulation or on an emulation platform. A host writes an eight-bit control code over a write path (data-in clocked by the serial clock and framed by an active-low write-select line). A valid code picks one of four 14-bit sample sources: angular rate, temperature, and two auxiliary inputs. Two further codes keep the rate source selected and add or subtract a fixed self-test offset.

A read is framed by an active-low read-select line. Its falling edge freezes the selected sample. The frozen value then leaves on data-out most significant bit first, in fixed serial-clock slots after a short lead-in. Outside a read the output enable is low, which stands for a high-impedance pin. The sample sources are plain parallel input ports, so the test environment sets them directly. All serial lines are sampled by the fast system clock, and edges are found from those samples.

Top module: `sensor_spi_target`

## Requirements
- R1: While `wsel_n` is low, `din` is shifted in on every falling edge of `sclk`, with the first bit becoming the most significant. On the rising edge of `wsel_n` only the last eight bits shifted are decoded, and any earlier bits are discarded. The control setting changes at no other time.
- R2: Code 0x20 selects the rate input, 0x10 the temperature input, 0x40 auxiliary input 1 and 0x80 auxiliary input 2. Each of these clears both self-test flags, and the selected input is sent unchanged as a 14-bit offset-binary value (zero rate reads 8192).
- R3: Code 0x22 selects rate with the positive self-test, which adds `ST_OFS` (6226) to the rate input. Code 0x21 selects rate with the negative self-test, which subtracts 6226.
- R4: A self-test result is clamped to the range 0 to 16383.
- R5: Any code other than the six listed leaves the channel selection and the self-test flags as they were.
- R6: While `rsel_n` is high, `dout_oe` is low and `dout` is 0.
- R7: The value sent in a frame is the selected value at the falling edge of `rsel_n`. Input changes after that edge do not alter the frame.
- R8: After `rsel_n` falls, bit 13 appears on `dout` after the 6th falling edge of `sclk`, and each later falling edge presents the next lower bit. Bit 0 appears after the 19th falling edge.
- R9: While `rsel_n` is low, `dout` is 0 after falling edges 1 to 5 and after falling edge 20 and every later one.
- R10: After reset the rate input is selected with no self-test, and `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial configuration data from the host |
| wsel_n | input | 1 | Active-low write select; its rising edge commits a code |
| rsel_n | input | 1 | Active-low read select; its falling edge freezes a sample |
| rate_in | input | 14 | Rate sample source |
| temp_in | input | 14 | Temperature sample source |
| aux1_in | input | 14 | Auxiliary sample source 1 |
| aux2_in | input | 14 | Auxiliary sample source 2 |
| dout | output | 1 | Serial sample data |
| dout_oe | output | 1 | Output enable for `dout`; low means high impedance |

## Verification
A wrong control setting shows in the very next read frame as the value of the wrong source, or as a rate value shifted by a self-test offset that should not be there. A miscounted slot counter moves every data bit to a neighbouring slot, so the frame shows a doubled or halved value or nonzero lead-in bits within the same frame. A snapshot that is not held shows as a frame mixing two input values once an input changes mid-frame. Saturation faults appear only near the range ends, so rate values at the exact clamp limits and one step inside them are applied with both self-test polarities.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic [1:0] {
    SRC_RATE = 2'd0,
    SRC_TEMP = 2'd1,
    SRC_AUX1 = 2'd2,
    SRC_AUX2 = 2'd3
  } src_e;

  typedef struct packed {
    src_e src;
    logic st_pos;
    logic st_neg;
  } ctrl_t;

  typedef struct packed {
    logic  hit;
    ctrl_t ctrl;
  } dec_t;

  localparam int CODE_W = 8;

  // one-hot channel bits: 7 aux2, 6 aux1, 5 rate, 4 temp; bit 1 / bit 0 self-test
  localparam logic [CODE_W-1:0] CODE_AUX2    = 8'h80;
  localparam logic [CODE_W-1:0] CODE_AUX1    = 8'h40;
  localparam logic [CODE_W-1:0] CODE_RATE    = 8'h20;
  localparam logic [CODE_W-1:0] CODE_TEMP    = 8'h10;
  localparam logic [CODE_W-1:0] CODE_RATE_SP = 8'h22;
  localparam logic [CODE_W-1:0] CODE_RATE_SN = 8'h21;

  localparam ctrl_t CTRL_RST = '{src: SRC_RATE, st_pos: 1'b0, st_neg: 1'b0};

  function automatic dec_t decode_code(input logic [CODE_W-1:0] code);
    dec_t r;
    r.hit  = 1'b1;
    r.ctrl = CTRL_RST;
    case (code)
      CODE_RATE:    r.ctrl.src = SRC_RATE;
      CODE_TEMP:    r.ctrl.src = SRC_TEMP;
      CODE_AUX1:    r.ctrl.src = SRC_AUX1;
      CODE_AUX2:    r.ctrl.src = SRC_AUX2;
      CODE_RATE_SP: r.ctrl.st_pos = 1'b1;
      CODE_RATE_SN: r.ctrl.st_neg = 1'b1;
      default:      r.hit = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sst_pin_sync.sv
// Samples a group of serial pins into the clk domain; exposes current and
// previous samples so the caller can form edges.
module sst_pin_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);

  logic [W-1:0] lvl_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= RST_VAL;
      prv_q <= RST_VAL;
    end else begin
      lvl_q <= pins;
      prv_q <= lvl_q;
    end
  end

  assign lvl = lvl_q;
  assign prv = prv_q;

endmodule

// File: rtl/sst_cfg_rx.sv
// Configuration receiver: shift register on the write path and control register.
module sst_cfg_rx
  import sst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_fall,
  input  logic  wsel_lvl,
  input  logic  wsel_rise,
  input  logic  din_lvl,
  output ctrl_t ctrl
);

  logic [CODE_W-1:0] sh_q, sh_d;
  ctrl_t             ctrl_q, ctrl_d;
  dec_t              dec;

  always_comb begin
    sh_d   = sh_q;
    ctrl_d = ctrl_q;
    dec    = decode_code(sh_q);
    if (sclk_fall && !wsel_lvl) begin
      sh_d = {sh_q[CODE_W-2:0], din_lvl};
    end
    if (wsel_rise && dec.hit) begin
      ctrl_d = dec.ctrl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      ctrl_q <= CTRL_RST;
    end else begin
      sh_q   <= sh_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/sst_src_mux.sv
// Picks the sample source and applies the clamped self-test offset to rate.
module sst_src_mux
  import sst_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int ST_OFS = 6226
) (
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] rate_in,
  input  logic [DATA_W-1:0] temp_in,
  input  logic [DATA_W-1:0] aux1_in,
  input  logic [DATA_W-1:0] aux2_in,
  output logic [DATA_W-1:0] sample
);

  localparam logic [DATA_W:0] OFS_X = (DATA_W+1)'(ST_OFS);
  localparam logic [DATA_W:0] MAX_X = {1'b0, {DATA_W{1'b1}}};

  logic [DATA_W:0]   rate_x;
  logic [DATA_W:0]   up_sum;
  logic [DATA_W:0]   dn_dif;
  logic [DATA_W-1:0] rate_st;

  always_comb begin
    rate_x  = {1'b0, rate_in};
    up_sum  = rate_x + OFS_X;
    dn_dif  = rate_x - OFS_X;
    rate_st = rate_in;
    if (ctrl.st_pos) begin
      rate_st = (up_sum > MAX_X) ? MAX_X[DATA_W-1:0] : up_sum[DATA_W-1:0];
    end else if (ctrl.st_neg) begin
      rate_st = (rate_x < OFS_X) ? '0 : dn_dif[DATA_W-1:0];
    end
    case (ctrl.src)
      SRC_RATE: sample = rate_st;
      SRC_TEMP: sample = temp_in;
      SRC_AUX1: sample = aux1_in;
      default:  sample = aux2_in;
    endcase
  end

endmodule

// File: rtl/sst_tx_frame.sv
// Read-path framer: snapshot on select fall, falling-edge slot counter,
// MSB-first data in slots LEAD+1 .. LEAD+DATA_W, zeros elsewhere.
module sst_tx_frame #(
  parameter int DATA_W = 14,
  parameter int LEAD   = 5,
  localparam int LAST  = LEAD + DATA_W,
  localparam int CW    = $clog2(LAST + 3),
  localparam int IW    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_fall,
  input  logic              rsel_lvl,
  input  logic              rsel_fall,
  input  logic [DATA_W-1:0] sample,
  output logic              dout,
  output logic              dout_oe,
  output logic [DATA_W-1:0] snap,
  output logic [CW-1:0]     cnt
);

  logic [DATA_W-1:0] snap_q, snap_d;
  logic [CW-1:0]     cnt_q, cnt_d, nxt;
  logic              bit_q, bit_d;
  logic              in_slot;
  logic [IW-1:0]     idx;

  always_comb begin
    snap_d  = snap_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    nxt     = cnt_q + CW'(1);
    in_slot = (nxt >= CW'(LEAD + 1)) && (nxt <= CW'(LAST));
    idx     = IW'(LAST - int'(nxt));
    if (rsel_lvl) begin
      bit_d = 1'b0;
    end else if (rsel_fall) begin
      snap_d = sample;
      cnt_d  = '0;
      bit_d  = 1'b0;
    end else if (sclk_fall) begin
      if (cnt_q != CW'(LAST + 1)) begin
        cnt_d = nxt;
      end
      bit_d = in_slot ? snap_q[idx] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      cnt_q  <= '0;
      bit_q  <= 1'b0;
    end else begin
      snap_q <= snap_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
    end
  end

  assign dout    = bit_q;
  assign dout_oe = !rsel_lvl;
  assign snap    = snap_q;
  assign cnt     = cnt_q;

endmodule

// File: rtl/sensor_spi_target.sv
module sensor_spi_target
  import sst_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int ST_OFS = 6226,
  parameter int LEAD   = 5,
  localparam int CW    = $clog2(LEAD + DATA_W + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              wsel_n,
  input  logic              rsel_n,
  input  logic [DATA_W-1:0] rate_in,
  input  logic [DATA_W-1:0] temp_in,
  input  logic [DATA_W-1:0] aux1_in,
  input  logic [DATA_W-1:0] aux2_in,
  output logic              dout,
  output logic              dout_oe
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  // pin bit order: [2] read select, [1] write select, [0] serial clock
  logic [2:0] pin_lvl, pin_prv;
  logic       din_q;

  sst_pin_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .pins  ({rsel_n, wsel_n, sclk}),
    .lvl   (pin_lvl),
    .prv   (pin_prv)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) din_q <= 1'b0;
    else          din_q <= din;
  end

  logic sclk_fall, wsel_lvl, wsel_rise, rsel_lvl, rsel_fall;
  assign sclk_fall = !pin_lvl[0] &&  pin_prv[0];
  assign wsel_lvl  =  pin_lvl[1];
  assign wsel_rise =  pin_lvl[1] && !pin_prv[1];
  assign rsel_lvl  =  pin_lvl[2];
  assign rsel_fall = !pin_lvl[2] &&  pin_prv[2];

  ctrl_t             ctrl;
  logic [DATA_W-1:0] sample;
  logic [DATA_W-1:0] snap;
  logic [CW-1:0]     cnt;

  sst_cfg_rx u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sclk_fall (sclk_fall),
    .wsel_lvl  (wsel_lvl),
    .wsel_rise (wsel_rise),
    .din_lvl   (din_q),
    .ctrl      (ctrl)
  );

  sst_src_mux #(.DATA_W(DATA_W), .ST_OFS(ST_OFS)) u_mux (
    .ctrl    (ctrl),
    .rate_in (rate_in),
    .temp_in (temp_in),
    .aux1_in (aux1_in),
    .aux2_in (aux2_in),
    .sample  (sample)
  );

  sst_tx_frame #(.DATA_W(DATA_W), .LEAD(LEAD)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sclk_fall (sclk_fall),
    .rsel_lvl  (rsel_lvl),
    .rsel_fall (rsel_fall),
    .sample    (sample),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .snap      (snap),
    .cnt       (cnt)
  );

endmodule

// File: rtl/sst_chk.sv
module sst_chk
  import sst_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int ST_OFS = 6226,
  parameter int LEAD   = 5,
  localparam int LAST  = LEAD + DATA_W,
  localparam int CW    = $clog2(LAST + 3)
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              rsel_n,
  input logic              rsel_lvl,
  input logic              rsel_fall,
  input logic              wsel_rise,
  input logic              dout,
  input logic              dout_oe,
  input ctrl_t             ctrl,
  input logic [DATA_W-1:0] rate_in,
  input logic [DATA_W-1:0] sample,
  input logic [DATA_W-1:0] snap,
  input logic [CW-1:0]     cnt
);

  localparam logic [DATA_W-1:0] MAXV = {DATA_W{1'b1}};

  p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    !wsel_rise |=> $stable(ctrl));

  p_st_rate_only_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (ctrl.st_pos || ctrl.st_neg) |-> (ctrl.src == SRC_RATE && !(ctrl.st_pos && ctrl.st_neg)));

  p_sat_hi_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (ctrl.src == SRC_RATE && ctrl.st_pos && int'(rate_in) + ST_OFS > int'(MAXV))
      |-> sample == MAXV);

  p_sat_lo_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (ctrl.src == SRC_RATE && ctrl.st_neg && int'(rate_in) < ST_OFS) |-> sample == '0);

  p_hiz_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    rsel_n |=> !dout_oe);

  p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (!rsel_lvl && !rsel_fall) |=> $stable(snap));

  p_lead_zero_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (!rsel_lvl && !rsel_fall && cnt <= CW'(LEAD)) |-> !dout);

  p_tail_zero_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (!rsel_lvl && !rsel_fall && cnt > CW'(LAST)) |-> !dout);

endmodule

bind sensor_spi_target sst_chk #(.DATA_W(DATA_W), .ST_OFS(ST_OFS), .LEAD(LEAD)) u_chk (
  .clk       (clk),
  .rst_ns    (rst_n_s),
  .rsel_n    (rsel_n),
  .rsel_lvl  (rsel_lvl),
  .rsel_fall (rsel_fall),
  .wsel_rise (wsel_rise),
  .dout      (dout),
  .dout_oe   (dout_oe),
  .ctrl      (ctrl),
  .rate_in   (rate_in),
  .sample    (sample),
  .snap      (snap),
  .cnt       (cnt)
);

// File: tb/sim_sensor_spi_target.sv
module sim_sensor_spi_target;

  localparam int DW   = 14;
  localparam int HALF = 8;   // clk cycles per serial half period
  localparam int NV   = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0;
  logic          din = 1'b0;
  logic          wsel_n = 1'b1;
  logic          rsel_n = 1'b1;
  logic [DW-1:0] rate_in = '0;
  logic [DW-1:0] temp_in = '0;
  logic [DW-1:0] aux1_in = '0;
  logic [DW-1:0] aux2_in = '0;
  logic          dout;
  logic          dout_oe;

  int n_chk = 0;
  int n_bad = 0;

  // mid-frame input change hook (used for R7)
  logic          mid_en = 1'b0;
  logic [DW-1:0] mid_val = '0;

  always #2 clk = ~clk;

  sensor_spi_target u0 (
    .clk (clk), .rst_n (rst_n), .sclk (sclk), .din (din),
    .wsel_n (wsel_n), .rsel_n (rsel_n),
    .rate_in (rate_in), .temp_in (temp_in), .aux1_in (aux1_in), .aux2_in (aux2_in),
    .dout (dout), .dout_oe (dout_oe)
  );

  // {req, code, rate, temp, aux1, aux2, expected}
  localparam logic [81:0] VEC [NV] = '{
    {4'd2, 8'h20, 14'd5000,  14'd7700, 14'd1234, 14'd16000, 14'd5000 },  // R2 rate
    {4'd2, 8'h10, 14'd5000,  14'd7700, 14'd1234, 14'd16000, 14'd7700 },  // R2 temp
    {4'd2, 8'h40, 14'd5000,  14'd7700, 14'd1234, 14'd16000, 14'd1234 },  // R2 aux1
    {4'd2, 8'h80, 14'd5000,  14'd7700, 14'd1234, 14'd16000, 14'd16000},  // R2 aux2
    {4'd3, 8'h22, 14'd8192,  14'd7700, 14'd1234, 14'd16000, 14'd14418},  // R3 positive
    {4'd3, 8'h21, 14'd8192,  14'd7700, 14'd1234, 14'd16000, 14'd1966 },  // R3 negative
    {4'd4, 8'h22, 14'd12000, 14'd7700, 14'd1234, 14'd16000, 14'd16383},  // R4 clamp high
    {4'd4, 8'h22, 14'd10157, 14'd7700, 14'd1234, 14'd16000, 14'd16383},  // R4 exact top
    {4'd4, 8'h22, 14'd10156, 14'd7700, 14'd1234, 14'd16000, 14'd16382},  // R4 just inside
    {4'd4, 8'h21, 14'd3000,  14'd7700, 14'd1234, 14'd16000, 14'd0    },  // R4 clamp low
    {4'd4, 8'h21, 14'd6227,  14'd7700, 14'd1234, 14'd16000, 14'd1    },  // R4 just inside
    {4'd4, 8'h21, 14'd6226,  14'd7700, 14'd1234, 14'd16000, 14'd0    },  // R4 exact bottom
    {4'd5, 8'h33, 14'd9000,  14'd7700, 14'd1234, 14'd16000, 14'd2774 },  // R5 keeps negative
    {4'd5, 8'h00, 14'd10000, 14'd7700, 14'd1234, 14'd16000, 14'd3774 },  // R5
    {4'd5, 8'h30, 14'd10000, 14'd7700, 14'd1234, 14'd16000, 14'd3774 },  // R5 two channel bits
    {4'd2, 8'h80, 14'd10000, 14'd7700, 14'd1234, 14'd15000, 14'd15000},  // R2 clears self-test
    {4'd5, 8'h02, 14'd10000, 14'd7700, 14'd1234, 14'd15000, 14'd15000},  // R5 flag without channel
    {4'd3, 8'h20, 14'd2000,  14'd7700, 14'd1234, 14'd15000, 14'd2000 }   // R3 self-test off
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [15:0] bits, input int n);
    wsel_n = 1'b0;
    wait_half();
    for (int i = n - 1; i >= 0; i--) begin
      din = bits[i];
      wait_half();
      sclk = 1'b1;
      wait_half();
      sclk = 1'b0;
      wait_half();
    end
    wsel_n = 1'b1;
    wait_half();
  endtask

  task automatic read_frame(output logic [DW-1:0] val, output bit zero_ok, output bit oe_ok);
    val = '0;
    zero_ok = 1'b1;
    oe_ok = 1'b1;
    rsel_n = 1'b0;
    wait_half();
    for (int f = 1; f <= 22; f++) begin
      sclk = 1'b1;
      wait_half();
      if (f == 3 && mid_en) rate_in = mid_val;
      sclk = 1'b0;
      wait_half();
      if (dout_oe !== 1'b1) oe_ok = 1'b0;
      if (f >= 6 && f <= 19) val[19-f] = dout;
      else if (dout !== 1'b0) zero_ok = 1'b0;
    end
    rsel_n = 1'b1;
    wait_half();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R8 watchdog actual=hung expected=complete");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    bit zok, ook;

    repeat (5) @(negedge clk);
    // R10: outputs during and right after reset
    check(dout_oe == 1'b0, "R10 oe in reset", int'(dout_oe), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(dout_oe == 1'b0, "R10 oe after reset", int'(dout_oe), 0);
    check(dout == 1'b0, "R6 dout idle", int'(dout), 0);

    // R10: default channel is rate, no self-test
    rate_in = 14'd8192; temp_in = 14'd100; aux1_in = 14'd200; aux2_in = 14'd300;
    read_frame(v, zok, ook);
    check(v == 14'd8192, "R10 default rate", int'(v), 8192);
    check(ook, "R6 oe during frame", int'(ook), 1);
    check(dout_oe == 1'b0, "R6 oe after frame", int'(dout_oe), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      rate_in = VEC[i][69:56];
      temp_in = VEC[i][55:42];
      aux1_in = VEC[i][41:28];
      aux2_in = VEC[i][27:14];
      write_cfg({8'h00, VEC[i][77:70]}, 8);
      read_frame(v, zok, ook);
      check(v == VEC[i][13:0], $sformatf("R%0d vec %0d", VEC[i][81:78], i),
            int'(v), int'(VEC[i][13:0]));
      check(zok, $sformatf("R9 vec %0d zero slots", i), int'(zok), 1);
      check(ook && dout_oe == 1'b0 && dout == 1'b0,
            $sformatf("R6 vec %0d enable", i), int'(dout_oe), 0);
    end

    // R1: sixteen bits shifted, only the last eight count (0x10 then 0x40)
    rate_in = 14'd111; temp_in = 14'd222; aux1_in = 14'd333; aux2_in = 14'd444;
    write_cfg(16'h1040, 16);
    read_frame(v, zok, ook);
    check(v == 14'd333, "R1 last eight bits", int'(v), 333);

    // R1: twelve bits, leading four garbage, last eight = 0x10
    write_cfg(16'h0F10, 12);
    read_frame(v, zok, ook);
    check(v == 14'd222, "R1 discard early bits", int'(v), 222);

    // R1: serial clock with write select high does not shift or commit
    wsel_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      din = 1'b1;
      sclk = 1'b1; wait_half();
      sclk = 1'b0; wait_half();
    end
    read_frame(v, zok, ook);
    check(v == 14'd222, "R1 no shift when deselected", int'(v), 222);

    // R7: rate changes mid-frame, frame keeps snapshot
    write_cfg(16'h0020, 8);
    rate_in = 14'h2AAA;
    mid_val = 14'h1555;
    mid_en = 1'b1;
    read_frame(v, zok, ook);
    mid_en = 1'b0;
    check(v == 14'h2AAA, "R7 snapshot held", int'(v), int'(14'h2AAA));
    read_frame(v, zok, ook);
    check(v == 14'h1555, "R7 next frame new value", int'(v), int'(14'h1555));

    // R8: single-bit patterns locate MSB and LSB slots
    rate_in = 14'h2000;
    read_frame(v, zok, ook);
    check(v == 14'h2000 && zok, "R8 MSB slot", int'(v), int'(14'h2000));
    rate_in = 14'h0001;
    read_frame(v, zok, ook);
    check(v == 14'h0001 && zok, "R8 LSB slot", int'(v), 1);
    rate_in = 14'h3FFF;
    read_frame(v, zok, ook);
    check(v == 14'h3FFF, "R8 all ones", int'(v), int'(14'h3FFF));
    check(zok, "R9 all ones framing", int'(zok), 1);

    summary();
    $finish;
  end

endmodule